// File: doc/BRIEF.md
# Voltage Sag and Current Fault Detector

This block watches the instantaneous samples of four measurement channels: two voltage channels and two current channels. Each channel has its own threshold level and its own window length, counted in samples. Within each window the block counts the samples whose magnitude lies below the threshold. At the end of the window it declares a sag (voltage channels) or a fault (current channels) if more than half of the samples in that window were below the threshold.

Each declaration sets a sticky status bit for its channel. Status bits are cleared one at a time by a write-one-to-clear strobe vector. A per-channel enable mask forms a single interrupt request from the status bits. A channel whose level or window length is zero is switched off and its window restarts from empty.

Top module: `sag_fault_detector`

## Requirements
- R1: A sample counts as below level only when its two's-complement magnitude is strictly less than the channel level; a magnitude equal to the level does not count, and the most negative code has magnitude 2^(SAMPLE_W-1).
- R2: Only cycles with `sampleValid` high advance a window; the decision is taken on the clock edge that accepts the window's last sample, the status bit is visible after that edge, and both counters then restart empty.
- R3: A channel declares an event when twice its below-level count exceeds its window length; exactly half the window below level declares nothing.
- R4: A channel whose level is zero or whose window length is zero never sets its status bit, and its counters are held empty.
- R5: Status bit mapping is bit 0 voltage sag, bit 1 voltage-2 sag, bit 2 current fault, bit 3 current-2 fault; a set bit stays set until cleared, whatever later samples arrive.
- R6: `statusClr` clears only the bits written as one, on the next edge; a detection on the same edge as a clear of that bit leaves the bit set.
- R7: `irq` is high exactly when some status bit is set and its bit in `irqEnable` is one.
- R8: After reset all status bits and `irq` are low.
- R9: The four channels are independent: samples below level on one channel set only that channel's bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| sampleValid | input | 1 | New sample on all four channels this cycle |
| voltSample | input | SAMPLE_W | Voltage channel sample, two's complement |
| volt2Sample | input | SAMPLE_W | Voltage-2 channel sample, two's complement |
| currSample | input | SAMPLE_W | Current channel sample, two's complement |
| curr2Sample | input | SAMPLE_W | Current-2 channel sample, two's complement |
| voltLevel | input | SAMPLE_W | Sag threshold magnitude, voltage channel |
| volt2Level | input | SAMPLE_W | Sag threshold magnitude, voltage-2 channel |
| currLevel | input | SAMPLE_W | Fault threshold magnitude, current channel |
| curr2Level | input | SAMPLE_W | Fault threshold magnitude, current-2 channel |
| voltDur | input | DUR_W | Sag window length in samples, voltage channel |
| volt2Dur | input | DUR_W | Sag window length in samples, voltage-2 channel |
| currDur | input | DUR_W | Fault window length in samples, current channel |
| curr2Dur | input | DUR_W | Fault window length in samples, current-2 channel |
| statusClr | input | 4 | Write-one-to-clear strobes for the status bits |
| irqEnable | input | 4 | Interrupt enable per status bit |
| status | output | 4 | Sticky sag/fault status bits |
| irq | output | 1 | Interrupt request |

## Verification
The bench targets the strict compare with samples equal to the level and the most negative code, which a design using less-or-equal or a naive absolute value would count as below. It drives windows with exactly half and one more than half of the samples below level, catching an off-by-one majority test, and holds `sampleValid` low to show a design counting idle cycles would trip. It collides a clear with a detection on the same edge, where a clear-wins design drops the bit, and checks that a zero level or zero window stays silent and that channels do not cross over.

// File: rtl/sfd_pkg.sv
package sfd_pkg;
  localparam int NUM_CH = 4;

  // strobes from the window control to the datapath of one channel
  typedef struct packed {
    logic active;   // level and window length both non-zero
    logic take;     // accept the sample presented this cycle
    logic winEnd;   // accepted sample is the last of its window
  } sfd_strobe_t;
endpackage

// File: rtl/sfd_window_ctrl.sv
module sfd_window_ctrl
  import sfd_pkg::*;
#(
  parameter int DUR_W = 12
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             sampleValid,
  input  logic             levelNonZero,
  input  logic [DUR_W-1:0] dur,
  output sfd_strobe_t      strobe
);
  logic [DUR_W-1:0] winCnt;
  logic [DUR_W:0]   winCntInc;
  logic             active;

  assign active    = levelNonZero && (dur != '0);
  assign winCntInc = {1'b0, winCnt} + 1'b1;

  always_comb begin
    strobe.active = active;
    strobe.take   = active && sampleValid;
    strobe.winEnd = active && sampleValid && (winCntInc >= {1'b0, dur});
  end

  always_ff @(posedge clk) begin
    if (!rstN || !active) begin
      winCnt <= '0;
    end else if (strobe.take) begin
      winCnt <= strobe.winEnd ? '0 : winCntInc[DUR_W-1:0];
    end
  end
endmodule

// File: rtl/sfd_datapath.sv
module sfd_datapath
  import sfd_pkg::*;
#(
  parameter int SAMPLE_W = 16,
  parameter int DUR_W    = 12
) (
  input  logic                clk,
  input  logic                rstN,
  input  sfd_strobe_t         strobe,
  input  logic [SAMPLE_W-1:0] sample,
  input  logic [SAMPLE_W-1:0] level,
  input  logic [DUR_W-1:0]    dur,
  output logic                detect
);
  logic [SAMPLE_W-1:0] mag;
  logic                below;
  logic [DUR_W-1:0]    belowCnt;
  logic [DUR_W:0]      belowNext;
  logic [DUR_W+1:0]    twiceBelow;

  // magnitude of a two's-complement code; the most negative code maps to 2^(W-1)
  assign mag        = sample[SAMPLE_W-1] ? (~sample + 1'b1) : sample;
  assign below      = mag < level;
  assign belowNext  = {1'b0, belowCnt} + {{DUR_W{1'b0}}, below};
  assign twiceBelow = {belowNext, 1'b0};
  assign detect     = strobe.winEnd && (twiceBelow > {2'b00, dur});

  always_ff @(posedge clk) begin
    if (!rstN || !strobe.active) begin
      belowCnt <= '0;
    end else if (strobe.winEnd) begin
      belowCnt <= '0;
    end else if (strobe.take) begin
      belowCnt <= belowNext[DUR_W-1:0];
    end
  end
endmodule

// File: rtl/sfd_status.sv
module sfd_status #(
  parameter int NUM_CH = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [NUM_CH-1:0] detect,
  input  logic [NUM_CH-1:0] clr,
  input  logic [NUM_CH-1:0] irqEnable,
  output logic [NUM_CH-1:0] status,
  output logic              irq
);
  always_ff @(posedge clk) begin
    if (!rstN) status <= '0;
    else       status <= (status & ~clr) | detect;
  end

  assign irq = |(status & irqEnable);
endmodule

// File: rtl/sag_fault_detector.sv
module sag_fault_detector
  import sfd_pkg::*;
#(
  parameter int SAMPLE_W = 16,
  parameter int DUR_W    = 12
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                sampleValid,
  input  logic [SAMPLE_W-1:0] voltSample,
  input  logic [SAMPLE_W-1:0] volt2Sample,
  input  logic [SAMPLE_W-1:0] currSample,
  input  logic [SAMPLE_W-1:0] curr2Sample,
  input  logic [SAMPLE_W-1:0] voltLevel,
  input  logic [SAMPLE_W-1:0] volt2Level,
  input  logic [SAMPLE_W-1:0] currLevel,
  input  logic [SAMPLE_W-1:0] curr2Level,
  input  logic [DUR_W-1:0]    voltDur,
  input  logic [DUR_W-1:0]    volt2Dur,
  input  logic [DUR_W-1:0]    currDur,
  input  logic [DUR_W-1:0]    curr2Dur,
  input  logic [3:0]          statusClr,
  input  logic [3:0]          irqEnable,
  output logic [3:0]          status,
  output logic                irq
);
  logic [SAMPLE_W-1:0] chSample [NUM_CH];
  logic [SAMPLE_W-1:0] chLevel  [NUM_CH];
  logic [DUR_W-1:0]    chDur    [NUM_CH];
  logic [NUM_CH-1:0]   chDetect;

  // channel index = status bit position
  assign chSample = '{voltSample, volt2Sample, currSample, curr2Sample};
  assign chLevel  = '{voltLevel, volt2Level, currLevel, curr2Level};
  assign chDur    = '{voltDur, volt2Dur, currDur, curr2Dur};

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
    sfd_strobe_t strobe;

    sfd_window_ctrl #(.DUR_W(DUR_W)) ctrl_i (
      .clk          (clk),
      .rstN         (rstN),
      .sampleValid  (sampleValid),
      .levelNonZero (chLevel[ch] != '0),
      .dur          (chDur[ch]),
      .strobe       (strobe)
    );

    sfd_datapath #(.SAMPLE_W(SAMPLE_W), .DUR_W(DUR_W)) dp_i (
      .clk    (clk),
      .rstN   (rstN),
      .strobe (strobe),
      .sample (chSample[ch]),
      .level  (chLevel[ch]),
      .dur    (chDur[ch]),
      .detect (chDetect[ch])
    );
  end

  sfd_status #(.NUM_CH(NUM_CH)) status_i (
    .clk       (clk),
    .rstN      (rstN),
    .detect    (chDetect),
    .clr       (statusClr),
    .irqEnable (irqEnable),
    .status    (status),
    .irq       (irq)
  );
endmodule

// File: rtl/sfd_checker.sv
module sfd_checker #(
  parameter int SAMPLE_W = 16,
  parameter int DUR_W    = 12
) (
  input logic                clk,
  input logic                rstN,
  input logic                sampleValid,
  input logic [SAMPLE_W-1:0] voltLevel,
  input logic [SAMPLE_W-1:0] volt2Level,
  input logic [SAMPLE_W-1:0] currLevel,
  input logic [SAMPLE_W-1:0] curr2Level,
  input logic [DUR_W-1:0]    voltDur,
  input logic [DUR_W-1:0]    volt2Dur,
  input logic [DUR_W-1:0]    currDur,
  input logic [DUR_W-1:0]    curr2Dur,
  input logic [3:0]          statusClr,
  input logic [3:0]          irqEnable,
  input logic [3:0]          status,
  input logic                irq
);
  logic [3:0] offCh;
  assign offCh = {(curr2Level == '0) || (curr2Dur == '0),
                  (currLevel  == '0) || (currDur  == '0),
                  (volt2Level == '0) || (volt2Dur == '0),
                  (voltLevel  == '0) || (voltDur  == '0)};

  AST_NO_SAMPLE_NO_SET: assert property (@(posedge clk) disable iff (!rstN)
    (!sampleValid && status == 4'b0000) |=> status == 4'b0000); // R2

  AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rstN)
    ((status & irqEnable) == 4'b0000) |-> !irq); // R7

  AST_IRQ_RAISED: assert property (@(posedge clk) disable iff (!rstN)
    ((status & irqEnable) != 4'b0000) |-> irq); // R7

  for (genvar b = 0; b < 4; b++) begin : g_bit
    AST_STATUS_STICKY: assert property (@(posedge clk) disable iff (!rstN)
      (status[b] && !statusClr[b]) |=> status[b]); // R5

    AST_OFF_CHANNEL_QUIET: assert property (@(posedge clk) disable iff (!rstN)
      (offCh[b] && !status[b]) |=> !status[b]); // R4
  end
endmodule

bind sag_fault_detector sfd_checker #(.SAMPLE_W(SAMPLE_W), .DUR_W(DUR_W)) chk_i (
  .clk(clk), .rstN(rstN), .sampleValid(sampleValid),
  .voltLevel(voltLevel), .volt2Level(volt2Level), .currLevel(currLevel), .curr2Level(curr2Level),
  .voltDur(voltDur), .volt2Dur(volt2Dur), .currDur(currDur), .curr2Dur(curr2Dur),
  .statusClr(statusClr), .irqEnable(irqEnable), .status(status), .irq(irq)
);

// File: tb/sag_fault_detector_tb_top.sv
module sag_fault_detector_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int SW = 16;
  localparam int DW = 12;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sampleValid = 1'b0;
  logic [SW-1:0] smp [4];
  logic [SW-1:0] lvl [4];
  logic [DW-1:0] dur [4];
  logic [3:0] statusClr = 4'b0;
  logic [3:0] irqEnable = 4'b0;
  logic [3:0] status;
  logic irq;
  int total = 0;
  int bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sag_fault_detector #(.SAMPLE_W(SW), .DUR_W(DW)) dut_i (
    .clk(clk), .rstN(rstN), .sampleValid(sampleValid),
    .voltSample(smp[0]), .volt2Sample(smp[1]), .currSample(smp[2]), .curr2Sample(smp[3]),
    .voltLevel(lvl[0]), .volt2Level(lvl[1]), .currLevel(lvl[2]), .curr2Level(lvl[3]),
    .voltDur(dur[0]), .volt2Dur(dur[1]), .currDur(dur[2]), .curr2Dur(dur[3]),
    .statusClr(statusClr), .irqEnable(irqEnable), .status(status), .irq(irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // one accepted sample on all channels, optionally with a clear on the same edge
  task automatic push(input int s0, input int s1, input int s2, input int s3,
                      input logic [3:0] clr = 4'b0);
    @(negedge clk);
    smp[0] = SW'(s0); smp[1] = SW'(s1); smp[2] = SW'(s2); smp[3] = SW'(s3);
    sampleValid = 1'b1; statusClr = clr;
    @(negedge clk);
    sampleValid = 1'b0; statusClr = 4'b0;
  endtask

  task automatic pushVolt(input int s0);
    push(s0, 20000, 20000, 20000);
  endtask

  task automatic clearBits(input logic [3:0] m);
    @(negedge clk); statusClr = m;
    @(negedge clk); statusClr = 4'b0;
  endtask

  task automatic quiesce();
    @(negedge clk);
    for (int i = 0; i < 4; i++) begin lvl[i] = '0; dur[i] = '0; end
    clearBits(4'hF);
  endtask

  task automatic cfg(input int ch, input int l, input int d);
    @(negedge clk); lvl[ch] = SW'(l); dur[ch] = DW'(d);
  endtask

  task automatic t_reset();
    check("R8 status after reset", 32'(status), 32'h0);
    check("R8 irq after reset", 32'(irq), 32'h0);
  endtask

  task automatic t_majority();
    quiesce(); cfg(0, 100, 4);
    pushVolt(50); pushVolt(-50); pushVolt(150);
    check("R2 no decision before window end", 32'(status), 32'h0);
    pushVolt(-20);
    check("R3 R5 sag on 3 of 4 below, bit0", 32'(status), 32'h1);
  endtask

  task automatic t_half();
    quiesce(); cfg(0, 100, 4);
    pushVolt(10); pushVolt(10); pushVolt(500); pushVolt(-500);
    check("R3 exactly half does not declare", 32'(status), 32'h0);
    cfg(0, 100, 3);
    pushVolt(10); pushVolt(-10); pushVolt(500);
    check("R3 two of three declares", 32'(status), 32'h1);
  endtask

  task automatic t_equal();
    quiesce(); cfg(0, 100, 4);
    pushVolt(100); pushVolt(-100); pushVolt(100); pushVolt(-100);
    check("r1_ equal magnitude is not below", 32'(status), 32'h0);
    pushVolt(-99); pushVolt(-99); pushVolt(-99); pushVolt(200);
    check("R1 negative magnitude below", 32'(status), 32'h1);
    quiesce(); cfg(0, 16'h7FFF, 1);
    pushVolt(-32768);
    check("R1 most negative code not below 7FFF", 32'(status), 32'h0);
    cfg(0, 16'hFFFF, 1);
    pushVolt(-32768);
    check("R1 most negative code below FFFF", 32'(status), 32'h1);
  endtask

  task automatic t_valid_gate();
    quiesce(); cfg(0, 100, 2);
    @(negedge clk); smp[0] = '0;
    repeat (20) @(negedge clk);
    check("R2 idle cycles do not advance window", 32'(status), 32'h0);
    pushVolt(0);
    check("R2 half window after idle", 32'(status), 32'h0);
    pushVolt(0);
    check("R2 window completes on valid samples", 32'(status), 32'h1);
  endtask

  task automatic t_disabled();
    quiesce(); cfg(0, 0, 4);
    repeat (8) pushVolt(0);
    check("R4 zero level disables", 32'(status), 32'h0);
    cfg(0, 100, 0);
    repeat (8) pushVolt(0);
    check("R4 zero duration disables", 32'(status), 32'h0);
    cfg(0, 100, 2);
    pushVolt(0);
    cfg(0, 0, 2);
    cfg(0, 100, 2);
    pushVolt(0);
    check("R4 disabling empties the window", 32'(status), 32'h0);
  endtask

  task automatic t_independent();
    quiesce();
    cfg(0, 100, 2); cfg(1, 100, 2); cfg(2, 100, 2); cfg(3, 100, 2);
    push(500, 500, 500, 5); push(-500, -500, -500, -5);
    check("R9 R5 only current-2 fault, bit3", 32'(status), 32'h8);
    push(5, 500, 500, 500); push(5, 500, 500, 500);
    check("R5 R9 voltage sag bit0 added", 32'(status), 32'h9);
  endtask

  task automatic t_sticky_clear();
    push(500, 500, 500, 500); push(500, 500, 500, 500);
    check("R5 status sticky under loud samples", 32'(status), 32'h9);
    clearBits(4'b0001);
    check("R6 clear only written bit", 32'(status), 32'h8);
    irqEnable = 4'b0001;
    #1 check("R7 masked bit gives no irq", 32'(irq), 32'h0);
    irqEnable = 4'b1000;
    #1 check("R7 enabled bit raises irq", 32'(irq), 32'h1);
    clearBits(4'b1000);
    check("R6 clear bit3", 32'(status), 32'h0);
    check("R7 irq drops after clear", 32'(irq), 32'h0);
    irqEnable = 4'b0;
  endtask

  task automatic t_collision();
    quiesce(); cfg(0, 100, 2);
    pushVolt(0); pushVolt(0);
    check("R6 setup bit0", 32'(status), 32'h1);
    pushVolt(0);
    push(0, 20000, 20000, 20000, 4'b0001);
    check("R6 detection wins over same-edge clear", 32'(status), 32'h1);
    push(0, 20000, 20000, 20000, 4'b0001);
    check("R6 clear without detection", 32'(status), 32'h0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 4; i++) begin smp[i] = '0; lvl[i] = '0; dur[i] = '0; end
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_majority();
    t_half();
    t_equal();
    t_valid_gate();
    t_disabled();
    t_independent();
    t_sticky_clear();
    t_collision();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule